// File: doc/BRIEF.md
# Fetch/Decode Hazard Controller

This block sits between the fetch and decode stages of a five-stage in-order pipeline. It holds the fetch/decode pipeline register and drives the steering signals for the program counter and the decode-stage control mux.

It watches for a load in the execute stage whose destination register is read by the instruction now in decode. When it sees one, it inserts one empty slot. The program counter and the fetch/decode register freeze, and the control bits sent on toward execute are forced to zero. The stages further down the pipe keep moving.

Branches are predicted not taken and are resolved in decode. When decode reports a jump, or a branch that is taken, the block squashes the instruction fetched behind it by loading an all-zero word into the fetch/decode register. Each redirect therefore costs exactly one slot.

Top module: `fd_hazard_ctrl`

## Requirements
- R1: A load-use hazard exists exactly when `ex_mem_read` is 1 and `ex_rt` equals `id_rs` or `id_rt`. With `ex_mem_read` at 0, or with neither field matching, no stall is raised.
- R2: While a hazard is present and no redirect is requested, `pc_write` and `ifid_write` are 0. `ifid_instr` and `ifid_pc` keep their values across the following clock edge.
- R3: `ctrl_zero` is 1 only in a stalled cycle. A load followed by a dependent instruction yields exactly one bubble cycle, because the stall clears as soon as the execute slot no longer holds a reading load.
- R4: When `id_jump` or `id_branch_taken` is 1, `if_flush` is 1. After the next edge, `ifid_instr` is all zeros (the no-op encoding) and `ifid_pc` equals the `if_pc` that was presented.
- R5: A redirect and a hazard in the same cycle resolve as a flush. `if_flush`, `pc_write` and `ifid_write` are 1, and `ctrl_zero` is 0.
- R6: With neither a hazard nor a redirect, `pc_write` and `ifid_write` are 1 and `if_flush` and `ctrl_zero` are 0. The fetch/decode register loads `if_instr` and `if_pc` on the edge.
- R7: While `rst` is 1 (synchronous, active high), `pc_write` and `ifid_write` are 1 and `if_flush` and `ctrl_zero` are 0. After a reset edge, `ifid_instr` and `ifid_pc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_mem_read | input | 1 | Instruction in execute reads data memory |
| ex_rt | input | REG_AW | Destination field of the instruction in execute |
| id_rs | input | REG_AW | First source field of the instruction in decode |
| id_rt | input | REG_AW | Second source field of the instruction in decode |
| id_jump | input | 1 | Decode holds a jump |
| id_branch_taken | input | 1 | Decode resolved a branch as taken |
| if_instr | input | INSTR_W | Instruction word from fetch |
| if_pc | input | PC_W | Address of the fetched word |
| pc_write | output | 1 | Program counter may advance |
| ifid_write | output | 1 | Fetch/decode register may load |
| ctrl_zero | output | 1 | Select all-zero control bits toward execute |
| if_flush | output | 1 | Squash the fetched instruction |
| ifid_instr | output | INSTR_W | Instruction held for decode |
| ifid_pc | output | PC_W | Address held for decode |

## Verification
The stimulus is random, with register fields drawn from a four-entry range so that both matching fields, only one matching field, and no matching field all occur often. This mix separates a compare that checks only one source field from one that checks both. Random cycles in which the load flag is low, or a redirect coincides with a hazard, show whether the read-flag gating and the flush-over-stall priority are present. Directed sequences replay a load followed by a dependent instruction and then count bubble cycles, and they apply a jump and a taken branch and then confirm the zero word and the held address in the fetch/decode register.

// File: rtl/fd_hazard_pkg.sv
`timescale 1ns/1ps
package fd_hazard_pkg;
  // Per-cycle decision of the hazard controller
  typedef enum logic [1:0] {
    ACT_RUN   = 2'd0,
    ACT_STALL = 2'd1,
    ACT_FLUSH = 2'd2
  } fd_action_e;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic zero_ctrl;
    logic squash;
  } fd_ctrl_t;

  function automatic fd_ctrl_t action_to_ctrl(fd_action_e a);
    fd_ctrl_t c;
    c = '{pc_we: 1'b1, ifid_we: 1'b1, zero_ctrl: 1'b0, squash: 1'b0};
    case (a)
      ACT_STALL: begin
        c.pc_we     = 1'b0;
        c.ifid_we   = 1'b0;
        c.zero_ctrl = 1'b1;
      end
      ACT_FLUSH: c.squash = 1'b1;
      default: ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/fd_loaduse_detect.sv
`timescale 1ns/1ps
module fd_loaduse_detect #(
  parameter int REG_AW = 5,
  parameter int N_SRC  = 2
) (
  input  logic                          ex_mem_read,
  input  logic [REG_AW-1:0]             ex_rt,
  input  logic [N_SRC-1:0][REG_AW-1:0]  id_src,
  output logic                          hazard
);
  logic [N_SRC-1:0] match;

  // One comparator per source operand read in decode
  for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
    assign match[g] = (id_src[g] == ex_rt);
  end

  assign hazard = ex_mem_read && (|match);
endmodule

// File: rtl/fd_action_arb.sv
`timescale 1ns/1ps
module fd_action_arb
  import fd_hazard_pkg::*;
(
  input  logic       rst,
  input  logic       hazard,
  input  logic       redirect,
  output fd_action_e action
);
  // The redirect outranks the stall so that the new fetch target is kept
  always_comb begin
    if (rst)           action = ACT_RUN;
    else if (redirect) action = ACT_FLUSH;
    else if (hazard)   action = ACT_STALL;
    else               action = ACT_RUN;
  end
endmodule

// File: rtl/fd_ifid_reg.sv
`timescale 1ns/1ps
module fd_ifid_reg #(
  parameter int INSTR_W = 32,
  parameter int PC_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               squash,
  input  logic [INSTR_W-1:0] d_instr,
  input  logic [PC_W-1:0]    d_pc,
  output logic [INSTR_W-1:0] q_instr,
  output logic [PC_W-1:0]    q_pc
);
  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_instr <= NOP_WORD;
      q_pc    <= '0;
    end else if (squash) begin
      q_instr <= NOP_WORD;
      q_pc    <= d_pc;
    end else if (load) begin
      q_instr <= d_instr;
      q_pc    <= d_pc;
    end
  end

  // R2: a closed write enable keeps the register contents
  a_r2_hold_contents: assert property (@(posedge clk) disable iff (rst)
    (!load && !squash) |=> ($stable(q_instr) && $stable(q_pc)));

  // R4: a squash leaves the no-op word behind
  a_r4_squash_to_nop: assert property (@(posedge clk) disable iff (rst)
    squash |=> (q_instr == NOP_WORD));
endmodule

// File: rtl/fd_hazard_ctrl.sv
`timescale 1ns/1ps
module fd_hazard_ctrl
  import fd_hazard_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int INSTR_W = 32,
  parameter int PC_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ex_mem_read,
  input  logic [REG_AW-1:0]  ex_rt,
  input  logic [REG_AW-1:0]  id_rs,
  input  logic [REG_AW-1:0]  id_rt,
  input  logic               id_jump,
  input  logic               id_branch_taken,
  input  logic [INSTR_W-1:0] if_instr,
  input  logic [PC_W-1:0]    if_pc,
  output logic               pc_write,
  output logic               ifid_write,
  output logic               ctrl_zero,
  output logic               if_flush,
  output logic [INSTR_W-1:0] ifid_instr,
  output logic [PC_W-1:0]    ifid_pc
);
  localparam int N_SRC = 2;

  logic [N_SRC-1:0][REG_AW-1:0] src_fields;
  logic       hazard;
  logic       redirect;
  fd_action_e action;
  fd_ctrl_t   ctrl;

  assign src_fields = {id_rt, id_rs};
  assign redirect   = id_jump || id_branch_taken;

  fd_loaduse_detect #(.REG_AW(REG_AW), .N_SRC(N_SRC)) u_detect (
    .ex_mem_read (ex_mem_read),
    .ex_rt       (ex_rt),
    .id_src      (src_fields),
    .hazard      (hazard)
  );

  fd_action_arb u_arb (
    .rst      (rst),
    .hazard   (hazard),
    .redirect (redirect),
    .action   (action)
  );

  assign ctrl       = action_to_ctrl(action);
  assign pc_write   = ctrl.pc_we;
  assign ifid_write = ctrl.ifid_we;
  assign ctrl_zero  = ctrl.zero_ctrl;
  assign if_flush   = ctrl.squash;

  fd_ifid_reg #(.INSTR_W(INSTR_W), .PC_W(PC_W)) u_ifid (
    .clk     (clk),
    .rst     (rst),
    .load    (ifid_write),
    .squash  (if_flush),
    .d_instr (if_instr),
    .d_pc    (if_pc),
    .q_instr (ifid_instr),
    .q_pc    (ifid_pc)
  );

  // R3: a bubble always comes with a frozen front end
  a_r3_bubble_freezes: assert property (@(posedge clk) disable iff (rst)
    ctrl_zero |-> (!pc_write && !ifid_write));

  // R5: a redirect is never swallowed by a stall
  a_r5_redirect_wins: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (if_flush && pc_write && !ctrl_zero));

  // R6: flush and bubble never coincide
  a_r6_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({if_flush, ctrl_zero}));

  // R1: a stall needs a memory read in execute
  a_r1_stall_needs_load: assert property (@(posedge clk) disable iff (rst)
    ctrl_zero |-> ex_mem_read);
endmodule

// File: tb/test_fd_hazard_ctrl.sv
`timescale 1ns/1ps
module test_fd_hazard_ctrl;
  localparam int RW = 5;
  localparam int IW = 32;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mr = 1'b0, j = 1'b0, bt = 1'b0;
  logic [RW-1:0] ert = '0, rs = '0, rt = '0;
  logic [IW-1:0] ins = '0;
  logic [PW-1:0] pc = '0;
  logic pc_write, ifid_write, ctrl_zero, if_flush;
  logic [IW-1:0] ifid_instr;
  logic [PW-1:0] ifid_pc;

  int n_checks = 0, n_fail = 0, bubbles = 0;
  bit done = 0;
  logic [IW-1:0] m_instr = '0;
  logic [PW-1:0] m_pc = '0;
  string last_tag = "R7";

  always #4 clk = ~clk;

  fd_hazard_ctrl #(.REG_AW(RW), .INSTR_W(IW), .PC_W(PW)) i_fd_hazard_ctrl (
    .clk(clk), .rst(rst), .ex_mem_read(mr), .ex_rt(ert), .id_rs(rs), .id_rt(rt),
    .id_jump(j), .id_branch_taken(bt), .if_instr(ins), .if_pc(pc),
    .pc_write(pc_write), .ifid_write(ifid_write), .ctrl_zero(ctrl_zero),
    .if_flush(if_flush), .ifid_instr(ifid_instr), .ifid_pc(ifid_pc));

  // Expected {pc_write, ifid_write, ctrl_zero, if_flush}
  function automatic logic [3:0] exp_ctrl(logic r, logic m, logic [RW-1:0] e,
      logic [RW-1:0] s, logic [RW-1:0] t, logic jj, logic bb);
    logic hz;
    hz = m && (e == s || e == t);
    if (r) return 4'b1100;
    if (jj || bb) return 4'b1101;
    if (hz) return 4'b0010;
    return 4'b1100;
  endfunction

  function automatic string tag_of(logic r, logic m, logic [RW-1:0] e,
      logic [RW-1:0] s, logic [RW-1:0] t, logic jj, logic bb);
    logic hz;
    hz = m && (e == s || e == t);
    if (r) return "R7";
    if ((jj || bb) && hz) return "R5";
    if (jj || bb) return "R4";
    if (hz) return "R2";
    if (m) return "R1";
    return "R6";
  endfunction

  // Reference model of the fetch/decode register
  always @(posedge clk) begin
    logic [3:0] e;
    e = exp_ctrl(rst, mr, ert, rs, rt, j, bt);
    last_tag = tag_of(rst, mr, ert, rs, rt, j, bt);
    if (rst) begin m_instr <= '0; m_pc <= '0; end
    else if (e[0]) begin m_instr <= '0; m_pc <= pc; end
    else if (e[2]) begin m_instr <= ins; m_pc <= pc; end
  end

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic r, logic m, logic [RW-1:0] e, logic [RW-1:0] s,
      logic [RW-1:0] t, logic jj, logic bb, logic [IW-1:0] w, logic [PW-1:0] p);
    logic [3:0] ex;
    string tg;
    @(negedge clk);
    check(last_tag, "ifid_instr", 64'(ifid_instr), 64'(m_instr));
    check(last_tag, "ifid_pc", 64'(ifid_pc), 64'(m_pc));
    rst = r; mr = m; ert = e; rs = s; rt = t; j = jj; bt = bb; ins = w; pc = p;
    #1;
    ex = exp_ctrl(r, m, e, s, t, jj, bb);
    tg = tag_of(r, m, e, s, t, jj, bb);
    if (ctrl_zero) bubbles++;
    check(tg, "ctrl{pcw,ifw,cz,fl}",
          64'({pc_write, ifid_write, ctrl_zero, if_flush}), 64'(ex));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240601));
    // R7: reset state with busy inputs
    step(1, 1, 5'd3, 5'd3, 5'd3, 1, 0, 32'hDEAD_BEEF, 32'h40);
    step(1, 0, 5'd0, 5'd0, 5'd0, 0, 0, 32'h1111_0000, 32'h44);
    // R6: plain flow
    step(0, 0, 5'd1, 5'd1, 5'd1, 0, 0, 32'h0123_4567, 32'h100);
    // R3 / R2: load then dependent add via rs, exactly one bubble
    bubbles = 0;
    step(0, 1, 5'd9, 5'd9, 5'd2, 0, 0, 32'h0AAA_0001, 32'h104);
    step(0, 0, 5'd0, 5'd9, 5'd2, 0, 0, 32'h0AAA_0001, 32'h104);
    step(0, 0, 5'd0, 5'd4, 5'd5, 0, 0, 32'h0BBB_0002, 32'h108);
    check("R3", "bubble count rs", 64'(bubbles), 64'd1);
    // R1: match on rt only
    bubbles = 0;
    step(0, 1, 5'd7, 5'd1, 5'd7, 0, 0, 32'h0CCC_0003, 32'h10C);
    step(0, 0, 5'd0, 5'd1, 5'd7, 0, 0, 32'h0CCC_0003, 32'h10C);
    check("R3", "bubble count rt", 64'(bubbles), 64'd1);
    // R1: match but no memory read
    step(0, 0, 5'd7, 5'd7, 5'd7, 0, 0, 32'h0DDD_0004, 32'h110);
    // R4: jump, then taken branch
    step(0, 0, 5'd0, 5'd1, 5'd2, 1, 0, 32'h0EEE_0005, 32'h114);
    step(0, 0, 5'd0, 5'd1, 5'd2, 0, 1, 32'h0FFF_0006, 32'h200);
    step(0, 0, 5'd0, 5'd1, 5'd2, 0, 0, 32'h0ABC_0007, 32'h300);
    // R5: redirect with hazard
    step(0, 1, 5'd6, 5'd6, 5'd6, 1, 0, 32'h0BCD_0008, 32'h304);
    step(0, 1, 5'd6, 5'd6, 5'd6, 0, 1, 32'h0CDE_0009, 32'h400);
    step(0, 0, 5'd0, 5'd0, 5'd1, 0, 0, 32'h0DEF_000A, 32'h500);
    // Random mix
    for (int k = 0; k < 3000; k++) begin
      step(($urandom_range(0, 99) < 2), ($urandom_range(0, 1) == 1),
           5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
           5'($urandom_range(0, 3)), ($urandom_range(0, 9) == 0),
           ($urandom_range(0, 9) == 0), $urandom, $urandom);
    end
    step(0, 0, 5'd0, 5'd1, 5'd2, 0, 0, 32'h0, 32'h0);
    finish_run();
  end
endmodule